// File: doc/BRIEF.md
# Case Branch and Interrupt Logic

This block sits beside a microprogram sequencer and works out where the next branch goes. It selects four conditions from a pool of external condition inputs and internal status flags. Each condition can be tested as true or as not-true. The four results form a 4-bit code, and the code picks one of sixteen branch targets. A fifth selector, with its own polarity, gives a single condition-true flag for conditional jumps and calls.

The same block also handles interrupts. External interrupt lines are edge-captured into pending latches, and an acknowledge for a source clears that source's latch. Internal interrupt sources are taken as levels. A mask register, written by the control path, enables each source. The enabled sources go through a fixed-priority encoder. The encoder gives an interrupt request with a vector, and a priority-CASE target offset from the branch base. The condition path and both targets are combinational. Only the pending latches, the edge history and the mask are registers.

Top module: `case_branch_unit`

## Requirements
- R1: Condition index k selects `ext_cond_i[k]` for k = 0..7 and `int_cond_i[k-8]` for k = 8..21. Selector values 22..31 read as a false condition.
- R2: A polarity bit of 1 inverts the selected condition, so the test is for not-true. A polarity bit of 0 tests for true.
- R3: Selector field j sits in `case_sel_i[5j+4:5j]` with polarity `case_pol_i[j]`, for j = 0..3. Its tested result drives bit j of `case_target_o`. Bits 9:4 of `case_target_o` equal `base_addr_i[9:4]`. The target follows the inputs in the same cycle.
- R4: `cond_true_o` equals the condition chosen by `jmp_sel_i`, XOR `jmp_pol_i`. It uses the index rules of R1.
- R5: A rising edge on `ext_irq_i[i]` sets pending bit i at the clock edge where the line is first sampled high after a low sample. A line that stays high does not set the bit again after it has been acknowledged.
- R6: A pending bit stays set until `irq_ack_i[i]` is high at a clock edge. An acknowledge for a different bit leaves it set. When an acknowledge and a new edge meet in the same cycle, the bit stays set.
- R7: The mask register loads `mask_wdata_i` at a clock edge where `mask_we_i` is high, and otherwise holds its value. Bit s enables source s. Sources 0..3 are `int_irq_i[0..3]` (levels) and sources 4..7 are pending bits 0..3. A masked pending bit is still captured and raises a request once it is unmasked.
- R8: Among the enabled active sources, the lowest index wins. `irq_vec_o` is that index, and `irq_req_o` is high when any enabled source is active.
- R9: `prio_target_o` is `base_addr_i` plus the winning index. With no enabled active source it is `base_addr_i` + 15. Both sums are taken modulo 1024.
- R10: After reset, the pending bits and the mask are zero, so `irq_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_cond_i | input | 8 | External condition inputs |
| int_cond_i | input | 14 | Internal status conditions |
| case_sel_i | input | 20 | Four 5-bit condition selectors for standard CASE |
| case_pol_i | input | 4 | Polarity per CASE selector (1 = not-true) |
| jmp_sel_i | input | 5 | Condition selector for jump/call |
| jmp_pol_i | input | 1 | Polarity for the jump/call test |
| base_addr_i | input | 10 | Branch base address |
| ext_irq_i | input | 4 | External interrupt lines, edge-captured |
| int_irq_i | input | 4 | Internal interrupt levels |
| irq_ack_i | input | 4 | Per-source clear of the external pending bits |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 8 | Mask register write data |
| case_target_o | output | 10 | Standard CASE branch target |
| prio_target_o | output | 10 | Priority CASE branch target |
| cond_true_o | output | 1 | Jump/call condition result |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 3 | Index of the winning interrupt source |

## Verification
Two things can land on the same pending bit in one cycle: a new external edge and the acknowledge for that bit. The bench sets a pending bit and drops the line. It then raises the line again in the same cycle that it asserts the acknowledge, and it expects the bit to survive. The pending state is read back through the request and vector outputs, with only the external sources unmasked. The bench also sweeps every mask value against every internal level pattern and every pending pattern. It compares the vector and the priority target with a lowest-set-bit computation done in the bench.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  // width of a standard CASE code: four conditions tested per cycle
  localparam int CASE_BITS = 4;
  // offset used by priority CASE when no source is active
  localparam int FALLTHRU_OFS = (1 << CASE_BITS) - 1;
endpackage

// File: rtl/cbu_cond_mux.sv
module cbu_cond_mux #(
  parameter int N_EXT = 8,
  parameter int N_INT = 14,
  parameter int SEL_W = 5
) (
  input  logic [N_EXT-1:0] ext_cond_i,
  input  logic [N_INT-1:0] int_cond_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pol_i,
  output logic             hit_o
);
  localparam int N_TOT = N_EXT + N_INT;
  localparam int N_PAD = 1 << SEL_W;

  logic [N_PAD-1:0] pool;

  // unused selector codes read as false before polarity
  always_comb begin
    pool = '0;
    pool[N_TOT-1:0] = {int_cond_i, ext_cond_i};
  end

  assign hit_o = pool[sel_i] ^ pol_i;
endmodule

// File: rtl/cbu_irq_capture.sv
module cbu_irq_capture #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] edge_det;

  assign edge_det = irq_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_i;
      // a fresh edge wins over an acknowledge in the same cycle
      pend_q <= (pend_q & ~ack_i) | edge_det;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_EDGE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[i] && !prev_q[i]) |=> pend_o[i]);                          // R5
    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !ack_i[i]) |=> pend_o[i]);                          // R6
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !(irq_i[i] && !prev_q[i])) |=> !pend_o[i]);          // R6
  end
endmodule

// File: rtl/cbu_prio_enc.sv
module cbu_prio_enc #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] grant_o
);
  // lowest index has the highest rank
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |req_i;
  assign grant_o = req_i & (~req_i + N_SRC'(1));

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));                                                 // R8
  AST_GRANT_MATCH_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (grant_o[idx_o] && req_i[idx_o]));                        // R8
endmodule

// File: rtl/case_branch_unit.sv
module case_branch_unit
  import cbu_pkg::*;
#(
  parameter int N_EXT_COND = 8,
  parameter int N_INT_COND = 14,
  parameter int N_EXT_IRQ  = 4,
  parameter int N_INT_IRQ  = 4,
  parameter int ADDR_W     = 10,
  localparam int SEL_W     = $clog2(N_EXT_COND + N_INT_COND),
  localparam int N_IRQ     = N_EXT_IRQ + N_INT_IRQ,
  localparam int VEC_W     = $clog2(N_IRQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_EXT_COND-1:0]  ext_cond_i,
  input  logic [N_INT_COND-1:0]  int_cond_i,
  input  logic [CASE_BITS*SEL_W-1:0] case_sel_i,
  input  logic [CASE_BITS-1:0]   case_pol_i,
  input  logic [SEL_W-1:0]       jmp_sel_i,
  input  logic                   jmp_pol_i,
  input  logic [ADDR_W-1:0]      base_addr_i,
  input  logic [N_EXT_IRQ-1:0]   ext_irq_i,
  input  logic [N_INT_IRQ-1:0]   int_irq_i,
  input  logic [N_EXT_IRQ-1:0]   irq_ack_i,
  input  logic                   mask_we_i,
  input  logic [N_IRQ-1:0]       mask_wdata_i,
  output logic [ADDR_W-1:0]      case_target_o,
  output logic [ADDR_W-1:0]      prio_target_o,
  output logic                   cond_true_o,
  output logic                   irq_req_o,
  output logic [VEC_W-1:0]       irq_vec_o
);
  logic [CASE_BITS-1:0] case_code;
  logic [N_EXT_IRQ-1:0] pend;
  logic [N_IRQ-1:0]     mask_q;
  logic [N_IRQ-1:0]     active;
  logic [N_IRQ-1:0]     grant;
  logic                 prio_hit;
  logic [VEC_W-1:0]     prio_idx;
  logic [ADDR_W-1:0]    prio_ofs;

  // condition testing: four CASE lanes plus one jump lane
  for (genvar j = 0; j < CASE_BITS; j++) begin : g_case
    cbu_cond_mux #(
      .N_EXT (N_EXT_COND),
      .N_INT (N_INT_COND),
      .SEL_W (SEL_W)
    ) u_mux (
      .ext_cond_i (ext_cond_i),
      .int_cond_i (int_cond_i),
      .sel_i      (case_sel_i[j*SEL_W +: SEL_W]),
      .pol_i      (case_pol_i[j]),
      .hit_o      (case_code[j])
    );
  end

  cbu_cond_mux #(
    .N_EXT (N_EXT_COND),
    .N_INT (N_INT_COND),
    .SEL_W (SEL_W)
  ) u_jmp_mux (
    .ext_cond_i (ext_cond_i),
    .int_cond_i (int_cond_i),
    .sel_i      (jmp_sel_i),
    .pol_i      (jmp_pol_i),
    .hit_o      (cond_true_o)
  );

  assign case_target_o = {base_addr_i[ADDR_W-1:CASE_BITS], case_code};

  // interrupt capture, mask and ranking
  cbu_irq_capture #(
    .N_SRC (N_EXT_IRQ)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (ext_irq_i),
    .ack_i  (irq_ack_i),
    .pend_o (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  // internal sources rank above external ones
  assign active = {pend, int_irq_i} & mask_q;

  cbu_prio_enc #(
    .N_SRC (N_IRQ),
    .IDX_W (VEC_W)
  ) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (active),
    .hit_o   (prio_hit),
    .idx_o   (prio_idx),
    .grant_o (grant)
  );

  assign prio_ofs      = prio_hit ? ADDR_W'(prio_idx) : ADDR_W'(FALLTHRU_OFS);
  assign prio_target_o = base_addr_i + prio_ofs;
  assign irq_req_o     = prio_hit;
  assign irq_vec_o     = prio_idx;

  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));                                    // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_req_o);                                     // R7
  AST_VEC_IS_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (mask_q[irq_vec_o] && grant[irq_vec_o]));             // R8
endmodule

// File: tb/case_branch_unit_tb_top.sv
module case_branch_unit_tb_top;
  // time unit taken as 1 ns: 10-unit period is the 100 MHz clock
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_cond = '0;
  logic [13:0] int_cond = '0;
  logic [19:0] case_sel = '0;
  logic [3:0]  case_pol = '0;
  logic [4:0]  jmp_sel = '0;
  logic        jmp_pol = 1'b0;
  logic [9:0]  base = '0;
  logic [3:0]  ext_irq = '0;
  logic [3:0]  int_irq = '0;
  logic [3:0]  ack = '0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wd = '0;
  logic [9:0]  case_target, prio_target;
  logic        cond_true, irq_req;
  logic [2:0]  irq_vec;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  case_branch_unit dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .ext_cond_i (ext_cond), .int_cond_i (int_cond),
    .case_sel_i (case_sel), .case_pol_i (case_pol),
    .jmp_sel_i (jmp_sel), .jmp_pol_i (jmp_pol),
    .base_addr_i (base),
    .ext_irq_i (ext_irq), .int_irq_i (int_irq), .irq_ack_i (ack),
    .mask_we_i (mask_we), .mask_wdata_i (mask_wd),
    .case_target_o (case_target), .prio_target_o (prio_target),
    .cond_true_o (cond_true), .irq_req_o (irq_req), .irq_vec_o (irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic bit exp_cond(int s, logic [7:0] e, logic [13:0] n);
    if (s < 8) return e[s];
    if (s < 22) return n[s-8];
    return 1'b0;
  endfunction

  // returns lowest set index of 8-bit vector, or -1
  function automatic int lowest(int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check_irq(string req, int act_vec_bits, int b);
    int w;
    w = lowest(act_vec_bits);
    chk({req, " req"}, int'(irq_req), (w >= 0) ? 1 : 0);
    if (w >= 0) chk({req, " vec"}, int'(irq_vec), w);
    chk({req, " target"}, int'(prio_target), (b + ((w >= 0) ? w : 15)) % 1024);
  endtask

  task automatic write_mask(logic [7:0] m);
    mask_we = 1'b1;
    mask_wd = m;
    step();
    mask_we = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int sel_k[4];
    logic [3:0] code;
    bit pol;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();

    // R10 reset state, R9 fall-through
    base = 10'd100;
    #1;
    chk("R10 req after reset", int'(irq_req), 0);
    chk("R9 fall-through after reset", int'(prio_target), 115);
    base = 10'd1020;
    #1;
    chk("R9 fall-through wraps", int'(prio_target), (1020 + 15) % 1024);

    // R1 R2 R3 R4: condition selection sweep
    for (int k = 0; k < 6; k++) begin
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 2; p++) begin
          if (k == 0) begin ext_cond = '0; int_cond = '0; end
          else if (k == 1) begin ext_cond = '1; int_cond = '1; end
          else begin
            ext_cond = 8'(8'hA5 ^ (k * 37 + s));
            int_cond = 14'(14'h2C3B ^ (k * 911 + s * 3));
          end
          sel_k[0] = s;
          sel_k[1] = (s + 5) % 32;
          sel_k[2] = (s + 11) % 32;
          sel_k[3] = (s + 17) % 32;
          pol = p[0];
          case_pol = {~pol, pol, ~pol, pol};
          case_sel = {5'(sel_k[3]), 5'(sel_k[2]), 5'(sel_k[1]), 5'(sel_k[0])};
          jmp_sel = 5'(s);
          jmp_pol = pol;
          base = 10'((s * 29 + k * 100) % 1024);
          #1;
          for (int j = 0; j < 4; j++)
            code[j] = exp_cond(sel_k[j], ext_cond, int_cond) ^ case_pol[j];
          chk("R1 R2 R3 case target", int'(case_target), int'({base[9:4], code}));
          chk("R1 R2 R4 jump condition", int'(cond_true),
              int'(exp_cond(s, ext_cond, int_cond) ^ pol));
        end
      end
    end

    // R5 R6: edge capture, acknowledge, collision (only external sources enabled)
    base = 10'd200;
    int_irq = '0;
    write_mask(8'hF0);
    #1 check_irq("R10 no pending before edge", 0, 200);
    ext_irq = 4'b0001;
    step();
    #1 check_irq("R5 edge sets pending", 8'h10, 200);
    ack = 4'b0010;
    step();
    ack = 4'b0000;
    #1 check_irq("R6 other ack keeps pending", 8'h10, 200);
    ack = 4'b0001;
    step();
    ack = 4'b0000;
    #1 check_irq("R6 ack clears pending", 0, 200);
    step();
    #1 check_irq("R5 held level no retrigger", 0, 200);
    ext_irq = 4'b0000;
    step();
    ext_irq = 4'b0001;
    step();
    ext_irq = 4'b0000;
    step();
    #1 check_irq("R6 pending holds after line drops", 8'h10, 200);
    ext_irq = 4'b0001;
    ack = 4'b0001;
    step();
    ack = 4'b0000;
    #1 check_irq("R6 edge and ack same cycle keep pending", 8'h10, 200);
    ack = 4'b0001;
    ext_irq = 4'b0000;
    step();
    ack = 4'b0000;
    #1 check_irq("R6 later ack clears", 0, 200);

    // R7 masked capture fires on unmask
    write_mask(8'h00);
    ext_irq = 4'b1000;
    step();
    ext_irq = 4'b0000;
    #1 check_irq("R7 masked pending quiet", 0, 200);
    write_mask(8'h80);
    #1 check_irq("R7 unmask reveals pending", 8'h80, 200);

    // R7 R8 R9: sweep of pending pattern x mask x internal levels
    for (int pp = 0; pp < 16; pp++) begin
      ext_irq = '0;
      int_irq = '0;
      ack = 4'hF;
      step();
      ack = '0;
      ext_irq = 4'(pp);
      step();
      ext_irq = '0;
      step();
      for (int m = 0; m < 256; m++) begin
        write_mask(8'(m));
        for (int iv = 0; iv < 16; iv++) begin
          int_irq = 4'(iv);
          base = 10'((pp * 61 + m * 7 + iv) % 1024);
          #1;
          check_irq("R7 R8 R9 sweep", ((pp << 4) | iv) & m, int'(base));
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule